// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Controller

This block keeps time of day in a cascade of four counters (seconds, minutes, hours and day of the week) and raises an interrupt when a chosen unit of time rolls over. Its time base is an external one-second strobe. The block counts on the rising edge of that strobe, so a strobe held high for several system clocks still counts once.

Software uses a small register port. One register holds a run request bit and a read-only running flag. The running flag takes the value of the run request on each strobe. A second register holds a compare-mode field and five periodic enables. The four time counters can be read at any time and preset while the clock is stopped. Writes to the interrupt control register and the time counters are accepted only when both the run request and the running flag are 0. The periodic interrupt is a single system-clock pulse.

Register map (byte-wide): address 0 holds bit 0 = run request (read/write) and bit 1 = running flag (read only). Address 1 is interrupt control. Address 2 is seconds, 3 is minutes, 4 is hours and 5 is day of week. Reads are combinational.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: A write to the interrupt control register (address 1) or to a time counter (addresses 2 to 5) is ignored while the run request or the running flag reads 1.
- R3: On each rising edge of `tick`, the running flag (address 0 bit 1) takes the value of the run request (bit 0). The counters advance on a rising edge of `tick` only when both bits were already 1 before that edge.
- R4: Seconds and minutes count 0 to 59, hours count 0 to 23 and day of week counts 0 to 6. Each counter wraps to 0 and carries into the next one.
- R5: The compare-mode field is bits 6:5 of address 1, where 00 means no compare and 01, 10 and 11 are compare modes 1 to 3. Any non-zero mode suppresses every periodic interrupt.
- R6: Bits 0 to 4 of address 1 enable interrupts on second, minute, hour, day and week. The second interrupt fires on every counting tick. The minute, hour, day and week interrupts fire when seconds, minutes, hours or day of week wrap, respectively.
- R7: If several enables are set, only the lowest-numbered set enable produces interrupts.
- R8: Bit 7 of address 1 is not stored. Writes to it are dropped and it reads 0.
- R9: A value written to a time counter that is above that counter's maximum is ignored.
- R10: `irq` rises in the clock cycle after the edge that sees the counting `tick` rise, and it stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-second strobe; its rising edge is used |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
A register write takes effect at the first clock edge after `wr_en` is presented. Reads are combinational, so the bench samples `rd_data` one time unit after it changes the address, half a cycle away from any edge. A strobe rise seen at a clock edge updates the counters, the running flag and `irq` together at that edge. The driver therefore queues an expected `irq` value for the half-cycle after that edge and a 0 for the half-cycle after the next edge, and the monitor pops one entry at each falling clock edge.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
    localparam int UNITS   = 4;
    localparam int SOURCES = UNITS + 1;
    localparam int CNT_W   = 6;

    typedef enum logic [2:0] {
        A_RUN  = 3'd0,
        A_CTRL = 3'd1,
        A_SEC  = 3'd2,
        A_MIN  = 3'd3,
        A_HOUR = 3'd4,
        A_DOW  = 3'd5
    } addr_e;

    typedef struct packed {
        logic [1:0]         mode;
        logic [SOURCES-1:0] en;
    } ctrl_t;

    function automatic int unit_limit(input int idx);
        case (idx)
            0:       return 59;
            1:       return 59;
            2:       return 23;
            default: return 6;
        endcase
    endfunction
endpackage

// File: rtl/rtc_ctrl_regs.sv
`timescale 1ns/1ps
module rtc_ctrl_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_rise,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              start_o,
    output logic              status_o,
    output logic              unlocked_o,
    output ctrl_t             ctrl_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic  start;
        logic  status;
        ctrl_t ctrl;
    } st_t;

    st_t st_d, st_q;
    logic unlocked;

    always_comb begin
        st_d     = st_q;
        unlocked = !st_q.start && !st_q.status;
        if (wr_en && wr_addr == ADDR_W'(A_RUN))
            st_d.start = wr_data[0];
        if (wr_en && unlocked && wr_addr == ADDR_W'(A_CTRL))
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
        if (tick_rise)
            st_d.status = st_q.start;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_o    = st_q.start;
    assign status_o   = st_q.status;
    assign unlocked_o = unlocked;
    assign ctrl_o     = st_q.ctrl;

    // R2: the control field cannot move while counting is requested or active
    p_ctrl_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start || st_q.status) |=> $stable(st_q.ctrl));
    // R3: the running flag changes only on a strobe rise
    p_status_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_rise |=> $stable(st_q.status));
endmodule

// File: rtl/rtc_unit_counter.sv
`timescale 1ns/1ps
module rtc_unit_counter #(
    parameter int W     = 6,
    parameter int LIMIT = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         carry_in,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_o,
    output logic         carry_out
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        carry_out = carry_in && (st_q.cnt == LIM);
        if (ld)
            st_d.cnt = ld_val;
        else if (carry_in)
            st_d.cnt = (st_q.cnt == LIM) ? '0 : st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R4: count never leaves its range
    p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM);
    // R3: without a carry or a load the count holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_in && !ld) |=> $stable(st_q.cnt));
endmodule

// File: rtl/rtc_time_chain.sv
`timescale 1ns/1ps
module rtc_time_chain
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance,
    input  logic                         load_ok,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [UNITS-1:0][CNT_W-1:0]  cnt_o,
    output logic [SOURCES-1:0]           events_o
);
    logic [UNITS:0] carry;
    assign carry[0] = advance;

    for (genvar i = 0; i < UNITS; i++) begin : g_unit
        localparam int LIM = unit_limit(i);
        logic ld;
        assign ld = wr_en && load_ok
                 && (wr_addr == ADDR_W'(int'(A_SEC) + i))
                 && (wr_data <= DATA_W'(LIM));
        rtc_unit_counter #(.W(CNT_W), .LIMIT(LIM)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .carry_in  (carry[i]),
            .ld        (ld),
            .ld_val    (wr_data[CNT_W-1:0]),
            .cnt_o     (cnt_o[i]),
            .carry_out (carry[i+1])
        );
    end

    assign events_o = carry;
endmodule

// File: rtl/rtc_irq_sel.sv
`timescale 1ns/1ps
module rtc_irq_sel
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl,
    input  logic [SOURCES-1:0] events,
    output logic               irq_o
);
    typedef struct packed {
        logic irq;
    } st_t;

    st_t st_d, st_q;
    logic [SOURCES-1:0] pick;

    always_comb begin
        pick       = ctrl.en & (~ctrl.en + SOURCES'(1));
        st_d.irq   = (ctrl.mode == 2'b00) && |(pick & events);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R5: any compare mode silences the periodic interrupt
    p_mode_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mode != 2'b00) |=> !st_q.irq);
    // R7: at most one source is honoured
    p_single_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick));
    // R6: no interrupt without a selected event
    p_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|events) |=> !st_q.irq);
endmodule

// File: rtl/rtc_periodic_irq.sv
`timescale 1ns/1ps
module rtc_periodic_irq
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    typedef struct packed {
        logic tick;
    } st_t;

    st_t st_d, st_q;
    logic tick_rise, start, status, unlocked, advance;
    ctrl_t ctrl;
    logic [UNITS-1:0][CNT_W-1:0] cnt;
    logic [SOURCES-1:0] events;

    always_comb begin
        st_d.tick = tick;
        tick_rise = tick && !st_q.tick;
        advance   = tick_rise && start && status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rtc_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_rise  (tick_rise),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .start_o    (start),
        .status_o   (status),
        .unlocked_o (unlocked),
        .ctrl_o     (ctrl)
    );

    rtc_time_chain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .load_ok  (unlocked),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cnt_o    (cnt),
        .events_o (events)
    );

    rtc_irq_sel u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl   (ctrl),
        .events (events),
        .irq_o  (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_RUN):  rd_data = DATA_W'({status, start});
            ADDR_W'(A_CTRL): rd_data = DATA_W'(ctrl);
            ADDR_W'(A_SEC):  rd_data = DATA_W'(cnt[0]);
            ADDR_W'(A_MIN):  rd_data = DATA_W'(cnt[1]);
            ADDR_W'(A_HOUR): rd_data = DATA_W'(cnt[2]);
            ADDR_W'(A_DOW):  rd_data = DATA_W'(cnt[3]);
            default:         rd_data = '0;
        endcase
    end

    // R10: interrupt is a single-cycle pulse
    p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: unimplemented control bit always reads 0
    p_bit7_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_W'(A_CTRL)) |-> !rd_data[DATA_W-1]);
endmodule

// File: tb/tb_rtc_periodic_irq.sv
`timescale 1ns/1ps
module tb_rtc_periodic_irq;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick = 0;
    logic       wr_en = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic [2:0] rd_addr = 0;
    logic [7:0] rd_data;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit    q_exp[$];
    string q_tag[$];

    // model state
    bit       m_start = 0, m_status = 0;
    bit [6:0] m_ctrl = 0;
    int       m_t[4] = '{0, 0, 0, 0};
    int       lim[4] = '{59, 59, 23, 6};

    always #5 clk = ~clk;

    rtc_periodic_irq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    // monitor: one queued expectation per falling edge
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            bit e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            n_cmp++;
            if (irq !== e) begin
                n_bad++;
                $display("FAIL %s irq: actual=%0b expected=%0b", t, irq, e);
            end
        end
    end

    function automatic bit [7:0] model_rd(input int a);
        case (a)
            0: return {6'd0, m_status, m_start};
            1: return {1'b0, m_ctrl};
            2, 3, 4, 5: return 8'(m_t[a-2]);
            default: return 8'd0;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic chk_rd(input int a, input string tag);
        @(negedge clk);
        rd_addr = 3'(a);
        #1;
        check(tag, int'(rd_data), int'(model_rd(a)));
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
        if (a == 0) m_start = d[0];
        else if (!m_start && !m_status) begin
            if (a == 1) m_ctrl = 7'(d);
            else if (a >= 2 && a <= 5 && d <= lim[a-2]) m_t[a-2] = d;
        end
    endtask

    task automatic do_tick(input string tag);
        bit [4:0] ev, en, low;
        bit exp;
        ev = 0;
        if (m_start && m_status) begin
            ev[0] = 1;
            for (int u = 0; u < 4; u++) begin
                if (ev[u]) begin
                    if (m_t[u] == lim[u]) begin m_t[u] = 0; ev[u+1] = 1; end
                    else m_t[u]++;
                end
            end
        end
        m_status = m_start;
        en  = m_ctrl[4:0];
        low = en & (~en + 5'd1);
        exp = (m_ctrl[6:5] == 2'b00) && |(low & ev);
        @(negedge clk);
        tick = 1;
        @(posedge clk);
        #1;
        tick = 0;
        q_exp.push_back(exp);  q_tag.push_back(tag);
        q_exp.push_back(1'b0); q_tag.push_back({tag, " R10 pulse end"});
        repeat (2) @(negedge clk);
    endtask

    task automatic stop_clock();
        wr(0, 0);
        do_tick("R3 stop tick");
    endtask

    task automatic start_clock();
        wr(0, 1);
        do_tick("R3 sync tick");
    endtask

    initial begin : watchdog
        #2000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 6; a++) chk_rd(a, "R1 reset reg");
        check("R1 reset irq", int'(irq), 0);

        // R8 bit 7 dropped
        wr(1, 8'h81);
        chk_rd(1, "R8 bit7 dropped");
        check("R8 literal", int'(rd_data), 1);

        // R3 start and sync
        wr(0, 1);
        chk_rd(0, "R3 start before tick");
        do_tick("R3 first tick no count");
        chk_rd(0, "R3 status follows start");
        chk_rd(2, "R3 no advance on sync tick");
        // R6 second interrupt
        for (int k = 0; k < 3; k++) do_tick("R6 second irq");
        chk_rd(2, "R6 seconds advanced");

        // R2 writes blocked while running
        wr(1, 8'h02);
        chk_rd(1, "R2 ctrl write blocked");
        wr(2, 10);
        chk_rd(2, "R2 time write blocked");
        wr(0, 0);
        chk_rd(0, "R3 status still set after stop request");
        wr(1, 8'h04);
        chk_rd(1, "R2 blocked by status flag");
        do_tick("R3 stop tick");
        chk_rd(0, "R3 status cleared");

        // R9 out of range presets
        wr(2, 60);
        chk_rd(2, "R9 seconds 60 ignored");
        wr(5, 7);
        chk_rd(5, "R9 dow 7 ignored");

        // R4/R6 full wrap with week enable
        wr(2, 59); wr(3, 59); wr(4, 23); wr(5, 6);
        wr(1, 8'h10);
        start_clock();
        do_tick("R6 week irq");
        for (int a = 2; a < 6; a++) chk_rd(a, "R4 full wrap to zero");

        // R6 hour enable, R4 day carry
        stop_clock();
        wr(4, 23); wr(3, 59); wr(2, 59);
        wr(1, 8'h04);
        start_clock();
        do_tick("R6 hour irq");
        chk_rd(4, "R4 hour wrap");
        chk_rd(5, "R4 dow carry");
        do_tick("R6 hour no irq mid hour");

        // R5 compare modes suppress
        for (int m = 1; m < 4; m++) begin
            stop_clock();
            wr(1, (m << 5) | 1);
            chk_rd(1, "R5 mode field readback");
            start_clock();
            do_tick("R5 mode suppresses irq");
        end

        // R7 several enables: minute wins over day and week
        stop_clock();
        wr(2, 58);
        wr(1, 8'h1A);
        start_clock();
        do_tick("R7 minute lowest, no wrap");
        do_tick("R7 minute lowest fires");

        // R7 second enable beats all
        stop_clock();
        wr(1, 8'h1F);
        start_clock();
        do_tick("R7 second lowest fires");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule